// File: doc/BRIEF.md
# Grouped Prescaler Tick Generator

This block turns one fast clock into five slower tick enables, one per timer channel. Two 8-bit prescalers divide the clock first. Channels 0 and 1 share the first prescaler, and channels 2, 3 and 4 share the second. Each channel then divides its prescaler's pulse train by a power of two that it selects itself. Every output is a one-cycle enable, meant to clock a down-counter elsewhere in the timer.

Software state arrives as two configuration words, each with its own write strobe. The rate word holds both prescaler values. The selection word holds five 4-bit divider selects. Any write to either word resets every prescaler and divider counter, so each channel starts a fresh period under the new settings.

Top module: `tickgen_bank`

## Requirements
- R1: After synchronous reset the rate word is 0x0101 and the selection word is 0. Every channel therefore ticks every 2 cycles, with its first tick visible one clock edge after the last reset edge.
- R2: Let P be the channel's prescaler value plus 1 and s its effective select. The channel's tick period is P·2^s clock cycles.
- R3: Rate-word bits [7:0] form prescaler 0. It drives channels 0 and 1 only, and their ticks appear only one cycle after a prescaler-0 pulse.
- R4: Rate-word bits [15:8] form prescaler 1. It drives channels 2, 3 and 4 only, and their ticks appear only one cycle after a prescaler-1 pulse.
- R5: The select for channel x is selection-word bits [4x+3:4x].
- R6: A select value above 4 acts as 4, which divides by 16.
- R7: A write to either word, sampled at clock edge E0, clears all ticks after E0. Counting edges after E0 as n, a channel ticks after edge n exactly when (n-1) mod (P·2^s) equals (2^s-1)·P. The same rule applies after reset, with E0 taken as the last reset edge.
- R8: Ticks are low during reset. A channel whose period exceeds one cycle never ticks in two consecutive cycles.
- R9: Rate-word bits [31:16] and selection-word bits [31:20] have no effect on any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_wr_i | input | 1 | Write strobe for the rate word |
| rate_data_i | input | 32 | Rate word: prescaler 0 in [7:0], prescaler 1 in [15:8] |
| sel_wr_i | input | 1 | Write strobe for the selection word |
| sel_data_i | input | 32 | Selection word: 4-bit select per channel |
| tick_o | output | 5 | One-cycle tick enable per channel |

## Verification
A wrong prescaler count or a missed reload moves the ticks of a whole channel group in phase. A wrong divider count or a wrong select moves only that one channel. Either error shows up at the tick outputs within the first period after the write or the reset. That is at most 4096 cycles with the largest settings, and often within a handful of cycles. The bench therefore compares the full tick vector every cycle against a phase formula, restarted at each write. A missing restart shows up as a phase offset from the first expected tick onward.

// File: rtl/tickgen_pkg.sv
// Shared constants and helpers for the grouped tick generator.
// Assumes exactly two prescaler groups; channels up to GRP0_LAST use group 0.
package tickgen_pkg;
    localparam int TG_GRP_NUM = 2;

    // Map a channel index to the prescaler group that feeds it.
    function automatic int unsigned grp_of(input int unsigned ch, input int unsigned grp0_last);
        return (ch <= grp0_last) ? 0 : 1;
    endfunction
endpackage

// File: rtl/tickgen_cfg_regs.sv
// Holds the used fields of the two configuration words.
// Assumes the words are written whole; unused bits are dropped here.
module tickgen_cfg_regs
    import tickgen_pkg::*;
#(
    parameter int CFG_W    = 32,
    parameter int CH_NUM   = 5,
    parameter int PRE_W    = 8,
    parameter int SEL_W    = 4,
    parameter logic [CFG_W-1:0] RATE_RST = 32'h0000_0101,
    parameter logic [CFG_W-1:0] SEL_RST  = '0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rate_wr_i,
    input  logic [CFG_W-1:0]                   rate_data_i,
    input  logic                               sel_wr_i,
    input  logic [CFG_W-1:0]                   sel_data_i,
    output logic [TG_GRP_NUM-1:0][PRE_W-1:0]   pre_o,
    output logic [CH_NUM-1:0][SEL_W-1:0]       sel_o,
    output logic                               restart_o
);
    // A write to either word restarts every counter at the same edge.
    assign restart_o = rate_wr_i | sel_wr_i;

    for (genvar g = 0; g < TG_GRP_NUM; g++) begin : g_pre
        // Store prescaler field g of the rate word.
        always_ff @(posedge clk) begin
            if (!rst_n)         pre_o[g] <= RATE_RST[g*PRE_W +: PRE_W];
            else if (rate_wr_i) pre_o[g] <= rate_data_i[g*PRE_W +: PRE_W];
        end
    end

    for (genvar c = 0; c < CH_NUM; c++) begin : g_sel
        // Store select field c of the selection word.
        always_ff @(posedge clk) begin
            if (!rst_n)        sel_o[c] <= SEL_RST[c*SEL_W +: SEL_W];
            else if (sel_wr_i) sel_o[c] <= sel_data_i[c*SEL_W +: SEL_W];
        end
    end
endmodule

// File: rtl/tickgen_prescaler.sv
// Down-counting prescaler: it pulses when the count is zero, then reloads.
// Assumes restart has priority over counting; the pulse is combinational.
module tickgen_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             pulse_o
);
    logic [PRE_W-1:0] cnt_q;

    // The count at zero marks the end of a prescaled period.
    assign pulse_o = (cnt_q == '0);

    // Count down, reload on zero, clear on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt_q <= '0;
        else if (pulse_o)        cnt_q <= pre_i;
        else                     cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/tickgen_chan_div.sv
// Per-channel power-of-two divider of the prescaler pulses, with a registered tick.
// Assumes selects above MAX_SEL saturate; the counter is MAX_SEL bits wide.
module tickgen_chan_div #(
    parameter int SEL_W   = 4,
    parameter int MAX_SEL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             step_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] eff_sel_o,
    output logic             tick_o
);
    localparam int DIV_W = (MAX_SEL > 0) ? MAX_SEL : 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W:0]   lim_full;
    logic             at_end;

    // Clamp the select to the deepest supported divider.
    assign eff_sel_o = (sel_i > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel_i;
    // The last count in a divider period is 2^sel - 1.
    assign span     = (DIV_W+1)'(1) << eff_sel_o;
    assign lim_full = span - 1'b1;
    assign at_end   = (div_q == lim_full[DIV_W-1:0]);

    // Count prescaler pulses and emit a tick on the last one of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            div_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= step_i && at_end;
            if (step_i) div_q <= at_end ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tickgen_bank.sv
// Top: two shared prescalers feed five channel dividers.
// Assumes CFG_W holds both prescaler fields and all channel select fields.
module tickgen_bank
    import tickgen_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int CH_NUM    = 5,
    parameter int PRE_W     = 8,
    parameter int SEL_W     = 4,
    parameter int MAX_SEL   = 4,
    parameter int GRP0_LAST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_wr_i,
    input  logic [CFG_W-1:0]  rate_data_i,
    input  logic              sel_wr_i,
    input  logic [CFG_W-1:0]  sel_data_i,
    output logic [CH_NUM-1:0] tick_o
);
    logic [TG_GRP_NUM-1:0][PRE_W-1:0] pre_val;
    logic [CH_NUM-1:0][SEL_W-1:0]     sel_val;
    logic [CH_NUM-1:0][SEL_W-1:0]     eff_sel;
    logic [TG_GRP_NUM-1:0]            grp_pulse;
    logic                             restart;

    tickgen_cfg_regs #(
        .CFG_W(CFG_W), .CH_NUM(CH_NUM), .PRE_W(PRE_W), .SEL_W(SEL_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .rate_wr_i(rate_wr_i), .rate_data_i(rate_data_i),
        .sel_wr_i(sel_wr_i), .sel_data_i(sel_data_i),
        .pre_o(pre_val), .sel_o(sel_val), .restart_o(restart)
    );

    for (genvar g = 0; g < TG_GRP_NUM; g++) begin : g_grp
        tickgen_prescaler #(.PRE_W(PRE_W)) pre_i (
            .clk(clk), .rst_n(rst_n), .restart_i(restart),
            .pre_i(pre_val[g]), .pulse_o(grp_pulse[g])
        );
    end

    for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
        localparam int GRP = grp_of(c, GRP0_LAST);
        tickgen_chan_div #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) div_i (
            .clk(clk), .rst_n(rst_n), .restart_i(restart),
            .step_i(grp_pulse[GRP]), .sel_i(sel_val[c]),
            .eff_sel_o(eff_sel[c]), .tick_o(tick_o[c])
        );
    end
endmodule

// File: rtl/tickgen_bank_chk.sv
// Property checker for tickgen_bank, attached through bind.
// Assumes it sees the group pulses and effective selects from the top.
module tickgen_bank_chk #(
    parameter int CH_NUM    = 5,
    parameter int SEL_W     = 4,
    parameter int GRP0_LAST = 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rate_wr_i,
    input logic                         sel_wr_i,
    input logic [CH_NUM-1:0]            tick_o,
    input logic [1:0]                   grp_pulse,
    input logic [CH_NUM-1:0][SEL_W-1:0] eff_sel
);
    // R8: the first cycle out of reset carries no tick.
    assert_quiet_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tick_o == '0));

    // R7: a configuration write clears every tick on the next cycle.
    assert_write_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_wr_i || sel_wr_i) |=> (tick_o == '0));

    for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
        if (c <= GRP0_LAST) begin : g_a
            // R3: a low channel ticks only after a prescaler-0 pulse.
            assert_grp0_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o[c] |-> $past(grp_pulse[0]));
        end else begin : g_b
            // R4: a high channel ticks only after a prescaler-1 pulse.
            assert_grp1_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o[c] |-> $past(grp_pulse[1]));
        end
        // R8: with a nonzero select, a tick never lasts two cycles.
        assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o[c] && (eff_sel[c] != '0)) |=> !tick_o[c]);
    end
endmodule

bind tickgen_bank tickgen_bank_chk #(
    .CH_NUM(CH_NUM), .SEL_W(SEL_W), .GRP0_LAST(GRP0_LAST)
) chk_i (
    .clk(clk), .rst_n(rst_n), .rate_wr_i(rate_wr_i), .sel_wr_i(sel_wr_i),
    .tick_o(tick_o), .grp_pulse(grp_pulse), .eff_sel(eff_sel)
);

// File: tb/tickgen_bank_tb_top.sv
// Directed bench: each scenario writes configuration and checks the tick phase every cycle.
module tickgen_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_wr = 1'b0;
    logic [31:0] rate_data = '0;
    logic        sel_wr = 1'b0;
    logic [31:0] sel_data = '0;
    logic [4:0]  tick;

    int checks = 0;
    int fails  = 0;
    logic [31:0] cur_rate = 32'h0000_0101;
    logic [31:0] cur_sel  = '0;
    bit done = 0;

    tickgen_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .rate_wr_i(rate_wr), .rate_data_i(rate_data),
        .sel_wr_i(sel_wr), .sel_data_i(sel_data),
        .tick_o(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick vector expected n edges after the restart edge.
    function automatic logic [4:0] model(input int n, input logic [31:0] rw, input logic [31:0] sw);
        logic [4:0] r;
        r = '0;
        for (int ch = 0; ch < 5; ch++) begin
            int p;
            int s;
            int per;
            p = (ch <= 1) ? int'(rw[7:0]) + 1 : int'(rw[15:8]) + 1;
            s = int'(sw[ch*4 +: 4]);
            if (s > 4) s = 4;
            per = p << s;
            r[ch] = (n >= 1) && (((n - 1) % per) == (((1 << s) - 1) * p));
        end
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [4:0] exp_v, input int n);
        checks++;
        if (tick !== exp_v) begin
            fails++;
            $display("FAIL %s cycle %0d: tick actual %b expected %b", tag, n, tick, exp_v);
        end
    endtask

    // Follow the expected phase for a number of cycles after a restart edge.
    task automatic follow(input string tag, input int cycles);
        for (int n = 0; n < cycles; n++) begin
            check_vec(tag, model(n, cur_rate, cur_sel), n);
            @(negedge clk);
        end
    endtask

    task automatic write_cfg(input bit do_rate, input logic [31:0] rw,
                             input bit do_sel, input logic [31:0] sw);
        @(negedge clk);
        rate_wr = do_rate; rate_data = rw;
        sel_wr = do_sel;   sel_data = sw;
        @(negedge clk);
        rate_wr = 1'b0; sel_wr = 1'b0;
        if (do_rate) cur_rate = rw;
        if (do_sel)  cur_sel = sw;
    endtask

    // R1 and R8: quiet during reset, then default rates.
    task automatic t_reset_defaults();
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check_vec("R8 reset low", 5'b0, -1);
        end
        rst_n = 1'b1;
        follow("R1 defaults", 40);
    endtask

    // R3 and R4: the two prescalers drive their own channel groups.
    task automatic t_groups();
        write_cfg(1, 32'h0000_0003, 1, 32'h0);
        follow("R3 R4 groups", 60);
        write_cfg(1, 32'h0000_0400, 0, 32'h0);
        follow("R4 R3 swapped", 60);
    endtask

    // R5 and R2: each channel takes its own select field.
    task automatic t_fields();
        write_cfg(1, 32'h0000_0201, 1, 32'h0004_3210);
        follow("R5 fields", 200);
    endtask

    // R6: selects above 4 saturate.
    task automatic t_saturate();
        write_cfg(0, 32'h0, 1, 32'h000F_9754);
        follow("R6 saturate", 200);
    endtask

    // R9: unused word bits are ignored.
    task automatic t_unused_bits();
        write_cfg(1, 32'hABCD_0201, 1, 32'hFFF0_1111);
        follow("R9 unused", 100);
    endtask

    // R7: a mid-period rewrite restarts every counter.
    task automatic t_restart();
        write_cfg(1, 32'h0000_0505, 1, 32'h0000_3333);
        follow("R7 first", 13);
        write_cfg(1, 32'h0000_0505, 0, 32'h0);
        follow("R7 rate rewrite", 120);
        write_cfg(0, 32'h0, 1, 32'h0000_3333);
        follow("R7 sel rewrite", 120);
    endtask

    // R2: longest periods.
    task automatic t_long();
        write_cfg(1, 32'h0000_FF07, 1, 32'h0004_4444);
        follow("R2 long", 9000);
    endtask

    initial begin
        t_reset_defaults();
        t_groups();
        t_fields();
        t_saturate();
        t_unused_bits();
        t_restart();
        t_long();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule